// File: doc/BRIEF.md
# Edge-Counting Autoreload Event Timer

This block is a down-counter that steps once per qualified transition of an external event input, not once per clock. The event input is brought into the clock domain by a short synchronizer chain. A registered copy of the synchronized level is compared with the level itself, so a step happens only on a real transition of the chosen polarity.

When the counter is at zero, the next counted event makes it underflow. The counter then reloads from an autoreload register, and a sticky pending flag is set. The interrupt output is raised while three things are all set: the pending flag, a local interrupt enable and a global enable input.

Software sets up the counter, the reload value, the mode, the run bit, the pending flag and the enable through a simple register write/read port. To get one underflow every N events, load N-1 into both the counter and the reload register. To count occurrences freely, load all ones.

Top module: `evt_reload_timer`

## Requirements
- R1: After reset, the count, reload, control, pending and enable registers all read zero and `irq` is low.
- R2: With the run bit (control bit 3) set and mode field (control bits 2:0) equal to 3'b100, each rising transition of `evt_in` decrements the count by exactly one. Falling transitions leave it unchanged.
- R3: With the run bit set and mode 3'b101, each falling transition of `evt_in` decrements the count by one. Rising transitions leave it unchanged.
- R4: While the run bit is clear, or while the mode field holds any value other than 3'b100 or 3'b101, transitions of `evt_in` leave the count unchanged.
- R5: A counted event that arrives while the count is zero reloads the count from the reload register and sets the pending flag. With N-1 loaded into both registers, exactly one underflow occurs every N events.
- R6: With the reload register at all ones, an event at count zero gives a count of all ones. Later events count down from that value.
- R7: The pending flag (bit 0 at address 3) stays set until software writes a 1 to bit 0 of address 3. A write of 0 leaves it unchanged.
- R8: `irq` is high exactly when the pending flag, the enable bit (bit 0 at address 4) and `glb_ie` are all high.
- R9: If a pending-clear write and an underflow land in the same cycle, the pending flag ends up set.
- R10: Changing the mode between 3'b100 and 3'b101 while `evt_in` is held steady produces no count step.
- R11: A write to the count (address 0) or the reload register (address 1) can be read back in the cycle after the write edge. A count write overrides any step in the same cycle.
- R12: An event level held for one or several clock cycles produces exactly one step per qualifying transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 count, 1 reload, 2 control, 3 pending, 4 enable) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | CNT_W | Combinational read data, zero-extended |
| evt_in | input | 1 | Asynchronous event input |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps reload values from 0 to 4 over three full periods each, with pulse widths of 1 to 3 cycles. A design that stepped on every cycle of a held level, or that underflowed on reaching zero rather than on the next event, would show the wrong count or the wrong underflow total. It lines up a pending-clear write with the exact edge of an underflow, where a design that let the clear win would lose the interrupt. It flips the edge polarity while the input is held steady: logic that compares against the polarity select would take a spurious step. It also drives all eight combinations of pending, local enable and global enable into the interrupt output.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   localparam logic [REG_ADDR_W-1:0] A_COUNT  = 3'd0;
   localparam logic [REG_ADDR_W-1:0] A_RELOAD = 3'd1;
   localparam logic [REG_ADDR_W-1:0] A_CTRL   = 3'd2;
   localparam logic [REG_ADDR_W-1:0] A_PEND   = 3'd3;
   localparam logic [REG_ADDR_W-1:0] A_IEN    = 3'd4;

   localparam int unsigned CTRL_W = 4;
   localparam int unsigned RUN_BIT = 3;

   localparam logic [2:0] MODE_EVT_RISE = 3'b100;
   localparam logic [2:0] MODE_EVT_FALL = 3'b101;

   typedef struct packed {
      logic       run;
      logic [2:0] mode;
   } ctrl_t;
endpackage

// File: rtl/evt_edge_det.sv
`timescale 1ns/1ps
module evt_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_in,
   input  logic fall_sel,
   output logic pulse
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evt_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
         prev_q <= sync_q[LAST];
      end
   end

   // Edge found from two registered samples only; polarity just picks which.
   logic rise, fall;
   assign rise  = sync_q[LAST] & ~prev_q;
   assign fall  = ~sync_q[LAST] & prev_q;
   assign pulse = fall_sel ? fall : rise;
endmodule

// File: rtl/evt_down_ctr.sv
`timescale 1ns/1ps
module evt_down_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] rel_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             uflow
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic at_zero;
   assign at_zero = (cnt == ZERO);
   assign uflow   = step & at_zero & ~ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= ZERO;
      else if (ld)
         cnt <= ld_val;
      else if (step)
         cnt <= at_zero ? rel_val : (cnt - ONE);
   end
endmodule

// File: rtl/evt_pend_irq.sv
`timescale 1ns/1ps
module evt_pend_irq #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ien,
   input  logic glb_ie,
   output logic pend,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (set)
         pend <= 1'b1;
      else if (clr)
         pend <= 1'b0;
   end

   logic irq_raw;
   assign irq_raw = pend & ien & glb_ie;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end
endmodule

// File: rtl/evt_reload_timer.sv
`timescale 1ns/1ps
module evt_reload_timer #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_IRQ     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             evt_in,
   input  logic             glb_ie,
   output logic             irq
);
   import evt_timer_pkg::*;

   localparam int unsigned PAD_CTRL = CNT_W - CTRL_W;
   localparam int unsigned PAD_BIT  = CNT_W - 1;

   if (CNT_W < 4) begin : g_bad_width
      $error("evt_reload_timer: CNT_W must be at least 4");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic             ien_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             evt_pulse, step, uflow;

   logic cnt_ld, rel_wr, ctrl_wr, ien_wr, pend_clr;
   assign cnt_ld   = wr_en & (wr_addr == A_COUNT);
   assign rel_wr   = wr_en & (wr_addr == A_RELOAD);
   assign ctrl_wr  = wr_en & (wr_addr == A_CTRL);
   assign ien_wr   = wr_en & (wr_addr == A_IEN);
   assign pend_clr = wr_en & (wr_addr == A_PEND) & wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         ien_q    <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (rel_wr)  reload_q <= wr_data;
         if (ien_wr)  ien_q    <= wr_data[0];
      end
   end

   logic run, evt_mode;
   assign run      = ctrl_q.run;
   assign evt_mode = (ctrl_q.mode == MODE_EVT_RISE) | (ctrl_q.mode == MODE_EVT_FALL);
   assign step     = evt_pulse & run & evt_mode;

   evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .fall_sel(ctrl_q.mode[0]), .pulse(evt_pulse)
   );

   evt_down_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(wr_data),
      .rel_val(reload_q), .step(step), .cnt(cnt_q), .uflow(uflow)
   );

   evt_pend_irq #(.REG_IRQ(REG_IRQ)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(uflow), .clr(pend_clr),
      .ien(ien_q), .glb_ie(glb_ie), .pend(pend_q), .irq(irq)
   );

   always_comb begin
      unique case (rd_addr)
         A_COUNT:  rd_data = cnt_q;
         A_RELOAD: rd_data = reload_q;
         A_CTRL:   rd_data = {{PAD_CTRL{1'b0}}, ctrl_q};
         A_PEND:   rd_data = {{PAD_BIT{1'b0}}, pend_q};
         A_IEN:    rd_data = {{PAD_BIT{1'b0}}, ien_q};
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          REG_IRQ = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rel,
   input logic             step,
   input logic             uflow,
   input logic             ld,
   input logic             pend,
   input logic             pend_clr,
   input logic             pulse,
   input logic             irq,
   input logic             glb_ie
);
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld) |=> $stable(cnt));

   assert_reload_on_uflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && cnt == '0) |=> (cnt == $past(rel) && pend));

   assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !pend_clr) |=> pend);

   assert_uflow_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && pend_clr) |=> pend);

   assert_one_pulse_per_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   if (!REG_IRQ) begin : g_comb_irq_chk
      assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (pend && glb_ie));
   end
endmodule

bind evt_reload_timer evt_timer_chk #(.CNT_W(CNT_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .rel(reload_q), .step(step),
   .uflow(uflow), .ld(cnt_ld), .pend(pend_q), .pend_clr(pend_clr),
   .pulse(evt_pulse), .irq(irq), .glb_ie(glb_ie)
);

// File: tb/evt_reload_timer_test.sv
`timescale 1ns/1ps
module evt_reload_timer_test;
   localparam int W = 16;
   localparam logic [2:0] AC = 3'd0, AR = 3'd1, ACT = 3'd2, AP = 3'd3, AI = 3'd4;
   localparam logic [W-1:0] RUN_RISE = 16'h000C, RUN_FALL = 16'h000D;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, evt_in = 1'b0, glb_ie = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [W-1:0] wr_data = '0, rd_data;
   logic irq;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   evt_reload_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .glb_ie(glb_ie), .irq(irq)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse(input int w);
      @(negedge clk) evt_in = 1'b1;
      repeat (w) @(negedge clk);
      evt_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic level(input logic v);
      @(negedge clk) evt_in = v;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, exp_c;
      int uf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v); check("R1", v, '0);
      end
      check("R1 irq", {15'b0, irq}, 16'd0);

      // R11 writes visible next cycle
      wr(AC, 16'h1234); rd(AC, v); check("R11 count", v, 16'h1234);
      wr(AR, 16'hABCD); rd(AR, v); check("R11 reload", v, 16'hABCD);

      // R4 stopped, or non-event mode
      wr(ACT, 16'h0004);
      for (int i = 0; i < 3; i++) pulse(2);
      rd(AC, v); check("R4 run clear", v, 16'h1234);
      wr(ACT, 16'h0008);
      for (int i = 0; i < 3; i++) pulse(2);
      rd(AC, v); check("R4 mode 000", v, 16'h1234);
      wr(ACT, 16'h000E);
      pulse(1);
      rd(AC, v); check("R4 mode 110", v, 16'h1234);

      // R2 R5 R12 sweep over period and pulse width
      for (int n = 1; n <= 5; n++) begin
         wr(ACT, 16'h0000);
         wr(AR, W'(n - 1)); wr(AC, W'(n - 1)); wr(AP, 16'h0001);
         wr(ACT, RUN_RISE);
         exp_c = W'(n - 1); uf = 0;
         for (int e = 0; e < 3 * n; e++) begin
            logic was_zero;
            was_zero = (exp_c == 0);
            pulse((e % 3) + 1);
            exp_c = was_zero ? W'(n - 1) : exp_c - 1'b1;
            rd(AC, v); check("R2 R12 count step", v, exp_c);
            rd(AP, v); check("R5 pending on underflow", v, {15'b0, was_zero});
            if (v[0]) begin uf++; wr(AP, 16'h0001); end
         end
         check("R5 underflows per 3N events", W'(uf), 16'd3);
      end

      // R3 falling mode
      wr(ACT, 16'h0000); wr(AC, 16'd5); wr(ACT, RUN_FALL);
      level(1'b1); rd(AC, v); check("R3 rise ignored", v, 16'd5);
      level(1'b0); rd(AC, v); check("R3 fall counted", v, 16'd4);

      // R10 polarity switch while steady
      level(1'b1); rd(AC, v); check("R10 base", v, 16'd4);
      wr(ACT, RUN_RISE); repeat (4) @(negedge clk);
      rd(AC, v); check("R10 fall->rise at high", v, 16'd4);
      wr(ACT, RUN_FALL); repeat (4) @(negedge clk);
      rd(AC, v); check("R10 rise->fall at high", v, 16'd4);
      level(1'b0); rd(AC, v); check("R10 real fall", v, 16'd3);
      wr(ACT, RUN_RISE); repeat (4) @(negedge clk);
      rd(AC, v); check("R10 fall->rise at low", v, 16'd3);

      // R6 all-ones reload
      wr(AP, 16'h0001); wr(AR, 16'hFFFF); wr(AC, 16'h0000);
      pulse(1); rd(AC, v); check("R6 wrap", v, 16'hFFFF);
      pulse(2); rd(AC, v); check("R6 continue", v, 16'hFFFE);

      // R7 sticky pending
      rd(AP, v); check("R7 set", v, 16'd1);
      wr(AP, 16'h0000); repeat (5) @(negedge clk);
      rd(AP, v); check("R7 write 0 no effect", v, 16'd1);
      wr(AP, 16'h0001); rd(AP, v); check("R7 clear", v, 16'd0);

      // R8 gating sweep
      for (int k = 0; k < 8; k++) begin
         wr(AP, 16'h0001);
         if (k[0]) begin wr(AC, 16'h0000); pulse(1); end
         wr(AI, {15'b0, k[1]});
         @(negedge clk) glb_ie = k[2];
         @(negedge clk);
         check("R8 irq", {15'b0, irq}, {15'b0, (k[0] & k[1] & k[2])});
      end
      glb_ie = 1'b0;

      // R9 clear write meets underflow edge
      wr(AC, 16'h0000); wr(AR, 16'h0007);
      rd(AP, v); check("R9 pre pend", v, 16'd1);
      @(negedge clk) evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AP; wr_data = 16'h0001;
      @(negedge clk);
      wr_en = 1'b0;
      rd(AP, v); check("R9 underflow wins", v, 16'd1);
      rd(AC, v); check("R9 reloaded", v, 16'h0007);
      level(1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule